// File: doc/BRIEF.md
# Dual-PHY Training Handshake Sequencer

This block runs one pattern-based training pass across a set of PHY instances (two by default), for either the read path or the write path. A single-cycle `go` pulse starts a run. The sequencer raises the start bit for the chosen direction on each PHY in turn and waits until every PHY reports done. It then lowers those start bits one PHY at a time and waits for every done flag again. To finish, it gives each PHY in turn a one-cycle pulse of its write-leveling mode bit and its command/address calibration mode bit, with both bits pulsed together.

A cycle-count timeout protects each of the two waits. The counter is reloaded when each wait begins. If a wait runs out, the run ends at once with a timeout status. No further steps run, and the start bits stay as they were. Otherwise the run ends with a success status. The status holds until the next `go`, and `busy` covers the whole run.

Top module: `vt_train_seq`

## Requirements
- R1: After synchronous reset, every start bit and mode bit is 0, `busy` is 0 and `status` is 2'b00 (idle).
- R2: A `go` sampled while idle makes `busy` 1 and `status` 2'b00 in the next cycle. `busy` stays 1 until the final status appears. A `go` sampled while `busy` is 1 has no effect on the run.
- R3: `dir_wr` is sampled with `go`. A value of 1 selects the `wr_start` bits and 0 selects the `rd_start` bits. The start bits of the other direction are never changed during the run.
- R4: The selected start bit of PHY 0 rises two cycles after `go`. Each next PHY follows one cycle later, and all are set before any waiting begins.
- R5: The first wait ends only when all `phy_done` bits are 1 together. The start bit of PHY 0 is cleared two cycles after the first cycle in which all done bits are seen high.
- R6: Start bits are cleared one PHY per cycle in ascending order. A second wait then needs all done bits high again. The first mode pulse comes two cycles after the first cycle in which that is seen.
- R7: After the second wait, each PHY in ascending order, two cycles apart, gets exactly one cycle with `wlvl_mode` and `cacal_mode` both high. No two PHYs pulse at the same time.
- R8: A wait that sees not-all-done for TIMEOUT+1 cycles ends the run. `status` becomes 2'b10 and `busy` becomes 0 in the cycle TIMEOUT+1 after the last start bit changed. No mode pulse follows, and the start bits keep their values.
- R9: On success, `status` becomes 2'b01 and `busy` becomes 0 one cycle after the last PHY's mode pulse. The status then holds until the next accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | One-cycle run request |
| dir_wr | input | 1 | 1 = write-direction training, 0 = read-direction |
| phy_done | input | NUM_PHY | Done flag from each PHY |
| wr_start | output | NUM_PHY | Write-direction start bit per PHY |
| rd_start | output | NUM_PHY | Read-direction start bit per PHY |
| wlvl_mode | output | NUM_PHY | Write-leveling mode bit per PHY |
| cacal_mode | output | NUM_PHY | Command/address calibration mode bit per PHY |
| busy | output | 1 | High from the cycle after `go` until the status is valid |
| status | output | 2 | 00 idle, 01 success, 10 timeout |

## Verification
The bench builds the block with NUM_PHY at 2 and TIMEOUT at 40 cycles. With these values a stalled PHY reaches the timeout within a few dozen cycles, in either wait. Random done latencies of up to 30 cycles stay just under that limit, so each success run still spends a long time counting down. The bench PHY models can hang on the rising start or on the falling start, so both waits reach their timeout exit. These runs also show the exact cycle at which the status changes.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SET, S_WAIT_HI, S_CLR, S_WAIT_LO, S_MON, S_MOFF
  } seq_st_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_OK   = 2'b01,
    ST_TMO  = 2'b10
  } stat_t;
endpackage

// File: rtl/vt_wait_timer.sv
module vt_wait_timer #(
  parameter int TIMEOUT = 100000,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= CW'(TIMEOUT);
    else if (step && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(TIMEOUT));
endmodule

// File: rtl/vt_phy_lane.sv
module vt_phy_lane (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic start_set,
  input  logic start_clr,
  input  logic use_wr,
  input  logic mode_on,
  input  logic mode_off,
  output logic wr_start_o,
  output logic rd_start_o,
  output logic wlvl_o,
  output logic cacal_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_start_o <= 1'b0;
      rd_start_o <= 1'b0;
      wlvl_o     <= 1'b0;
      cacal_o    <= 1'b0;
    end else if (hit) begin
      if (start_set) begin
        if (use_wr) wr_start_o <= 1'b1;
        else        rd_start_o <= 1'b1;
      end
      if (start_clr) begin
        if (use_wr) wr_start_o <= 1'b0;
        else        rd_start_o <= 1'b0;
      end
      if (mode_on) begin
        wlvl_o  <= 1'b1;
        cacal_o <= 1'b1;
      end
      if (mode_off) begin
        wlvl_o  <= 1'b0;
        cacal_o <= 1'b0;
      end
    end
  end

  // R7
  lane_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    wlvl_o |=> !wlvl_o);
endmodule

// File: rtl/vt_train_seq.sv
module vt_train_seq
  import vt_pkg::*;
#(
  parameter int NUM_PHY = 2,
  parameter int TIMEOUT = 100000,
  localparam int IW = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               dir_wr,
  input  logic [NUM_PHY-1:0] phy_done,
  output logic [NUM_PHY-1:0] wr_start,
  output logic [NUM_PHY-1:0] rd_start,
  output logic [NUM_PHY-1:0] wlvl_mode,
  output logic [NUM_PHY-1:0] cacal_mode,
  output logic               busy,
  output logic [1:0]         status
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_PHY - 1);

  seq_st_t       st_q;
  stat_t         stat_q;
  logic [IW-1:0] idx_q;
  logic          dir_q, busy_q;
  logic          all_done, expired, tmr_load, tmr_step;
  logic          in_wait, at_last;

  assign all_done = &phy_done;
  assign at_last  = (idx_q == LAST_IDX);
  assign in_wait  = (st_q == S_WAIT_HI) || (st_q == S_WAIT_LO);
  assign tmr_load = ((st_q == S_SET) || (st_q == S_CLR)) && at_last;
  assign tmr_step = in_wait && !all_done;

  vt_wait_timer #(.TIMEOUT(TIMEOUT)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load), .step(tmr_step), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      stat_q <= ST_IDLE;
      idx_q  <= '0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (go) begin
          busy_q <= 1'b1;
          stat_q <= ST_IDLE;
          dir_q  <= dir_wr;
          idx_q  <= '0;
          st_q   <= S_SET;
        end
        S_SET, S_CLR: begin
          if (at_last) begin
            idx_q <= '0;
            st_q  <= (st_q == S_SET) ? S_WAIT_HI : S_WAIT_LO;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_WAIT_HI, S_WAIT_LO: begin
          if (all_done) begin
            st_q <= (st_q == S_WAIT_HI) ? S_CLR : S_MON;
          end else if (expired) begin
            st_q   <= S_IDLE;
            busy_q <= 1'b0;
            stat_q <= ST_TMO;
          end
        end
        S_MON: st_q <= S_MOFF;
        S_MOFF: begin
          if (at_last) begin
            st_q   <= S_IDLE;
            busy_q <= 1'b0;
            stat_q <= ST_OK;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_MON;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_lane
    vt_phy_lane lane_i (
      .clk(clk), .rst(rst),
      .hit(idx_q == IW'(g)),
      .start_set(st_q == S_SET),
      .start_clr(st_q == S_CLR),
      .use_wr(dir_q),
      .mode_on(st_q == S_MON),
      .mode_off(st_q == S_MOFF),
      .wr_start_o(wr_start[g]),
      .rd_start_o(rd_start[g]),
      .wlvl_o(wlvl_mode[g]),
      .cacal_o(cacal_mode[g])
    );
  end

  assign busy   = busy_q;
  assign status = stat_q;

  // R2
  busy_status_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> status == ST_IDLE);
  // R7
  one_lane_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wlvl_mode));
  // R6
  mode_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|wlvl_mode) |-> ((dir_q ? wr_start : rd_start) == '0));
  // R3
  other_dir_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !dir_q) |=> $stable(wr_start));
  // R9
  ok_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (status == ST_OK && $past(status) != ST_OK) |-> $past(wlvl_mode[NUM_PHY-1]));
endmodule

// File: tb/vt_train_seq_tb.sv
`timescale 1ns/1ps
module vt_train_seq_tb_top;
  localparam int NP  = 2;
  localparam int TMO = 40;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0, dir_wr = 1'b0;
  logic [NP-1:0] phy_done, wr_start, rd_start, wlvl_mode, cacal_mode;
  logic busy;
  logic [1:0] status;

  int checks = 0, errors = 0;
  int dly [NP];
  bit hang_hi [NP];
  bit hang_lo [NP];

  always #2 clk = ~clk;

  vt_train_seq #(.NUM_PHY(NP), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .go(go), .dir_wr(dir_wr), .phy_done(phy_done),
    .wr_start(wr_start), .rd_start(rd_start), .wlvl_mode(wlvl_mode),
    .cacal_mode(cacal_mode), .busy(busy), .status(status)
  );

  // PHY models: done drops after a start change, returns dly cycles later
  for (genvar p = 0; p < NP; p++) begin : g_phy
    logic prev_s;
    int   cnt;
    always @(posedge clk) begin
      if (rst) begin
        phy_done[p] <= 1'b1; prev_s <= 1'b0; cnt <= 0;
      end else begin
        prev_s <= wr_start[p] | rd_start[p];
        if ((wr_start[p] | rd_start[p]) != prev_s) begin
          phy_done[p] <= 1'b0; cnt <= dly[p];
        end else if (cnt > 1) begin
          cnt <= cnt - 1;
        end else if (cnt == 1) begin
          cnt <= 0;
          if (!((prev_s && hang_hi[p]) || (!prev_s && hang_lo[p])))
            phy_done[p] <= 1'b1;
        end
      end
    end
  end

  function automatic int exp_tmo_at(input int last_change);
    return last_change + TMO + 1;
  endfunction

  function automatic int exp_after_wait(input int all_done_seen);
    return all_done_seen + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_run(input bit wr, input int d0, input int d1,
                        input bit h_hi1, input bit h_lo0, input int extra_go);
    int rise[NP], fall[NP], mfirst[NP], mcnt[NP];
    int alld1, alld2, end_t, t;
    bit mism, oth_seen;
    logic [NP-1:0] sel, oth;
    dly[0] = d0; dly[1] = d1;
    hang_hi[0] = 0; hang_hi[1] = h_hi1;
    hang_lo[0] = h_lo0; hang_lo[1] = 0;
    for (int i = 0; i < NP; i++) begin
      rise[i] = -1; fall[i] = -1; mfirst[i] = -1; mcnt[i] = 0;
    end
    alld1 = -1; alld2 = -1; end_t = -1; mism = 0; oth_seen = 0;
    go = 1'b1; dir_wr = wr;
    t = 0;
    while (end_t < 0 && t < 400) begin
      @(negedge clk);
      t++;
      go = (t == extra_go);
      dir_wr = ~wr;
      sel = wr ? wr_start : rd_start;
      oth = wr ? rd_start : wr_start;
      if (t == 1) begin
        chk(busy == 1'b1, "R2 busy after go", busy, 1);
        chk(status == 2'b00, "R2 status idle while busy", status, 0);
      end
      if (oth != '0) oth_seen = 1;
      for (int i = 0; i < NP; i++) begin
        if (sel[i] && rise[i] < 0) rise[i] = t;
        if (!sel[i] && rise[i] >= 0 && fall[i] < 0) fall[i] = t;
        if (wlvl_mode[i]) begin
          mcnt[i]++;
          if (mfirst[i] < 0) mfirst[i] = t;
        end
        if (wlvl_mode[i] != cacal_mode[i]) mism = 1;
      end
      if (alld1 < 0 && sel == '1 && phy_done == '1) alld1 = t;
      if (alld2 < 0 && fall[NP-1] >= 0 && phy_done == '1) alld2 = t;
      if (!busy) end_t = t;
    end
    go = 1'b0;
    chk(oth_seen == 0, "R3 other direction untouched", oth_seen, 0);
    chk(rise[0] == 2, "R4 PHY0 start timing", rise[0], 2);
    chk(rise[1] == rise[0] + 1, "R4 PHY1 start one cycle later", rise[1], rise[0] + 1);
    if (h_hi1) begin
      chk(end_t == exp_tmo_at(rise[1]), "R8 first-wait timeout cycle", end_t, exp_tmo_at(rise[1]));
      chk(status == 2'b10, "R8 timeout status", status, 2);
      chk(mcnt[0] + mcnt[1] == 0, "R8 no mode pulse", mcnt[0] + mcnt[1], 0);
      chk(sel == '1, "R8 start bits kept", sel, 3);
    end else if (h_lo0) begin
      chk(end_t == exp_tmo_at(fall[1]), "R8 second-wait timeout cycle", end_t, exp_tmo_at(fall[1]));
      chk(status == 2'b10, "R8 timeout status", status, 2);
      chk(mcnt[0] + mcnt[1] == 0, "R8 no mode pulse", mcnt[0] + mcnt[1], 0);
      chk(sel == '0, "R8 start bits kept", sel, 0);
    end else begin
      chk(fall[0] == exp_after_wait(alld1), "R5 clear after all done", fall[0], exp_after_wait(alld1));
      chk(fall[1] == fall[0] + 1, "R6 clear order", fall[1], fall[0] + 1);
      chk(mfirst[0] == exp_after_wait(alld2), "R6 mode after second wait", mfirst[0], exp_after_wait(alld2));
      chk(mfirst[1] == mfirst[0] + 2, "R7 PHY1 pulse order", mfirst[1], mfirst[0] + 2);
      chk(mcnt[0] == 1 && mcnt[1] == 1, "R7 one-cycle pulses", mcnt[0] * 10 + mcnt[1], 11);
      chk(mism == 0, "R7 mode bits together", mism, 0);
      chk(end_t == mfirst[1] + 1, "R9 busy drop cycle", end_t, mfirst[1] + 1);
      chk(status == 2'b01, "R9 success status", status, 1);
      repeat (3) @(negedge clk);
      chk(status == 2'b01 && !busy, "R9 status holds", status, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NP; i++) begin
      dly[i] = 3; hang_hi[i] = 0; hang_lo[i] = 0;
    end
    do_reset();
    // R1 reset state
    chk(wr_start == '0 && rd_start == '0, "R1 start bits reset", {wr_start, rd_start}, 0);
    chk(wlvl_mode == '0 && cacal_mode == '0, "R1 mode bits reset", {wlvl_mode, cacal_mode}, 0);
    chk(!busy && status == 2'b00, "R1 busy/status reset", {busy, status}, 0);
    do_run(1'b0, 3, 3, 0, 0, 0);
    do_run(1'b1, 12, 4, 0, 0, 0);
    // R2 go while busy is ignored
    do_run(1'b0, 6, 9, 0, 0, 5);
    do_run(1'b1, 2, 30, 0, 0, 12);
    for (int k = 0; k < 8; k++)
      do_run(1'($urandom_range(0, 1)), int'($urandom_range(2, 30)),
             int'($urandom_range(2, 30)), 0, 0, 0);
    do_run(1'b0, 5, 5, 1, 0, 0);
    do_reset();
    do_run(1'b1, 5, 5, 0, 1, 0);
    do_reset();
    do_run(1'b1, 30, 30, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule